// File: doc/BRIEF.md
# PRBS-15 Synchronisation and Bit-Error Monitor

This block watches a serial bit stream that should carry an unframed pseudo-random test pattern. Each accepted bit is compared with the bit a local reference generator predicts. A synchronisation state machine decides whether the monitor is locked to the incoming pattern. While it is out of lock, the monitor keeps reloading its reference from the received bits. While it is in lock, it flags every bit that differs from the prediction.

The reference is a 15-stage linear feedback register with the polynomial x^15 + x^14 + 1. Its history register holds the last fifteen bits. While hunting, those are the received bits, so a correct pattern is predicted from the sixteenth bit onward. While locked, the history holds the generator's own predictions, so errors on the line do not corrupt it. A bit is processed only in a cycle where its qualifier is high. The monitor produces two outputs: a level that is high while out of lock, and a one-cycle pulse for each bit error seen while locked.

Top module: `prbs_sync_mon`

## Requirements
- R1: During and after reset, before any valid bit, `oos` is 1 and `bit_err` is 0.
- R2: The predicted bit is h[13] XOR h[14], where h[0] is the most recent bit in the 15-bit history. While out of lock, each accepted bit is shifted into the history. On the clock edge that accepts the 32nd consecutive matching bit, `oos` falls to 0.
- R3: While out of lock, an accepted bit that does not match its prediction resets the consecutive-match run to zero. After 31 matches followed by one mismatch, 32 further matches are needed before `oos` falls.
- R4: While in lock, the prediction is shifted into the history in place of the received bit. Each accepted bit that differs from the prediction raises `bit_err` for exactly the one cycle after the edge that accepted it.
- R5: While in lock, four consecutive mismatching accepted bits set `oos` to 1 on the edge of the fourth, and that fourth bit also raises `bit_err`. Any matching accepted bit resets the mismatch run, so a run of three mismatches, then one match, then three more mismatches keeps the lock.
- R6: `bit_err` is never raised for a bit accepted while out of lock.
- R7: In a cycle where `bit_vld` is 0, `bit_in` is ignored: on the following edge `oos` keeps its value and `bit_err` is 0.
- R8: After lock is lost, the history is reloaded from received bits again, and 32 consecutive matches restore the lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bit_vld | input | 1 | Qualifier: `bit_in` is processed in this cycle |
| bit_in | input | 1 | Serial data bit under test |
| oos | output | 1 | Out-of-lock status level, 1 while hunting |
| bit_err | output | 1 | One-cycle pulse for a mismatched bit while in lock |

## Verification
Both results are registered, so `oos` and `bit_err` reflect a bit that was driven in one cycle just after the next rising edge, and stay there until the edge after that. After reset is released externally, the internal release takes two further edges. The driver therefore sends only idle cycles during that window. For every cycle it drives, the driver pushes one expected pair of `oos` and `bit_err` onto a queue. The monitor pops and compares one pair a nanosecond after each rising edge, so each comparison falls inside the single cycle in which that result is valid. The test sequences place the fourth mismatch, the 32nd match and the 31-then-miss case on known bits, so the boundary edges are the ones compared.

// File: rtl/prbsmon_pkg.sv
package prbsmon_pkg;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } sync_st_t;

endpackage

// File: rtl/prbsmon_rstsync.sv
module prbsmon_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else begin
      sr_q <= sr_d;
    end
  end

  assign rst_sync_n = sr_q[STAGES-1];

endmodule

// File: rtl/prbsmon_refgen.sv
module prbsmon_refgen #(
  parameter int LEN   = 15,
  parameter int TAP_A = 14,
  parameter int TAP_B = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic free_run,
  input  logic rx_bit,
  output logic pred_bit
);

  localparam logic [LEN-1:0] TAP_MASK =
    (LEN'(1) << (TAP_A - 1)) | (LEN'(1) << (TAP_B - 1));

  logic [LEN-1:0] hist_q;
  logic [LEN-1:0] hist_d;
  logic           shift_in;

  // Feedback taken from the selected history stages.
  assign pred_bit = ^(hist_q & TAP_MASK);

  // Locked: self-running; hunting: reseeded from the line.
  always_comb begin
    shift_in = free_run ? pred_bit : rx_bit;
    hist_d   = hist_q;
    if (adv) begin
      hist_d = {hist_q[LEN-2:0], shift_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else begin
      hist_q <= hist_d;
    end
  end

endmodule

// File: rtl/prbsmon_syncfsm.sv
module prbsmon_syncfsm
  import prbsmon_pkg::*;
#(
  parameter int LOCK_RUN = 32,
  parameter int LOSS_RUN = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     adv,
  input  logic     match,
  output sync_st_t st_q
);

  localparam int MW = $clog2(LOCK_RUN + 1);
  localparam int EW = $clog2(LOSS_RUN + 1);
  localparam logic [MW-1:0] M_LAST = MW'(LOCK_RUN - 1);
  localparam logic [EW-1:0] E_LAST = EW'(LOSS_RUN - 1);

  sync_st_t      st_d;
  logic [MW-1:0] mrun_q, mrun_d;
  logic [EW-1:0] erun_q, erun_d;

  always_comb begin
    st_d   = st_q;
    mrun_d = mrun_q;
    erun_d = erun_q;
    if (adv) begin
      case (st_q)
        ST_HUNT: begin
          erun_d = '0;
          if (match) begin
            if (mrun_q == M_LAST) begin
              st_d   = ST_LOCK;
              mrun_d = '0;
            end else begin
              mrun_d = mrun_q + 1'b1;
            end
          end else begin
            mrun_d = '0;
          end
        end
        ST_LOCK: begin
          mrun_d = '0;
          if (match) begin
            erun_d = '0;
          end else if (erun_q == E_LAST) begin
            st_d   = ST_HUNT;
            erun_d = '0;
          end else begin
            erun_d = erun_q + 1'b1;
          end
        end
        default: begin
          st_d   = ST_HUNT;
          mrun_d = '0;
          erun_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HUNT;
      mrun_q <= '0;
      erun_q <= '0;
    end else begin
      st_q   <= st_d;
      mrun_q <= mrun_d;
      erun_q <= erun_d;
    end
  end

endmodule

// File: rtl/prbsmon_errflag.sv
module prbsmon_errflag (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic locked,
  input  logic match,
  output logic err_q
);

  logic err_d;

  always_comb begin
    err_d = adv & locked & ~match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

endmodule

// File: rtl/prbs_sync_mon.sv
module prbs_sync_mon
  import prbsmon_pkg::*;
#(
  parameter int LFSR_LEN   = 15,
  parameter int TAP_A      = 14,
  parameter int LOCK_RUN   = 32,
  parameter int LOSS_RUN   = 4,
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_in,
  output logic oos,
  output logic bit_err
);

  logic     rst_i_n;
  logic     pred_bit;
  logic     match;
  logic     locked;
  sync_st_t st;

  prbsmon_rstsync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_i_n)
  );

  prbsmon_refgen #(
    .LEN  (LFSR_LEN),
    .TAP_A(TAP_A),
    .TAP_B(LFSR_LEN)
  ) u_ref (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .adv     (bit_vld),
    .free_run(locked),
    .rx_bit  (bit_in),
    .pred_bit(pred_bit)
  );

  assign match  = (bit_in == pred_bit);
  assign locked = (st == ST_LOCK);

  prbsmon_syncfsm #(
    .LOCK_RUN(LOCK_RUN),
    .LOSS_RUN(LOSS_RUN)
  ) u_fsm (
    .clk  (clk),
    .rst_n(rst_i_n),
    .adv  (bit_vld),
    .match(match),
    .st_q (st)
  );

  prbsmon_errflag u_err (
    .clk   (clk),
    .rst_n (rst_i_n),
    .adv   (bit_vld),
    .locked(locked),
    .match (match),
    .err_q (bit_err)
  );

  assign oos = ~locked;

endmodule

// File: rtl/prbsmon_chk.sv
module prbsmon_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_vld,
  input logic oos,
  input logic bit_err
);

  // Valid bits accepted since the monitor last left lock (saturating).
  logic [7:0] hunt_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hunt_run <= '0;
    end else if (!oos) begin
      hunt_run <= '0;
    end else if (bit_vld && hunt_run != 8'hFF) begin
      hunt_run <= hunt_run + 8'd1;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_state_r1: assert (oos && !bit_err)
        else $error("R1 reset state wrong");
    end
  end

  p_lock_after_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oos) |-> hunt_run >= 8'd32)
    else $error("R2 lock before 32 bits");

  p_loss_with_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oos) |-> bit_err)
    else $error("R5 lock lost without error");

  p_err_in_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_err |-> $past(!oos && bit_vld))
    else $error("R6 error while hunting");

  p_idle_no_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> !bit_err)
    else $error("R7 error on idle cycle");

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> $stable(oos))
    else $error("R7 status moved on idle cycle");

endmodule

bind prbs_sync_mon prbsmon_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .bit_vld(bit_vld),
  .oos    (oos),
  .bit_err(bit_err)
);

// File: tb/sim_prbs_sync_mon.sv
module sim_prbs_sync_mon;

  logic clk     = 1'b0;
  logic rst_n   = 1'b1;
  logic bit_vld = 1'b0;
  logic bit_in  = 1'b0;
  logic oos;
  logic bit_err;

  always #2 clk = ~clk;

  prbs_sync_mon u0 (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_vld(bit_vld),
    .bit_in (bit_in),
    .oos    (oos),
    .bit_err(bit_err)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  int    cyc   = 0;
  logic [1:0] q_exp[$];
  string      q_tag[$];
  string      tag = "R1";

  // Reference model built from the requirements.
  logic [14:0] m_hist = '0;
  logic        m_lock = 1'b0;
  int          m_mrun = 0;
  int          m_erun = 0;
  logic [14:0] gen    = 15'h4A3;

  task automatic drive(input logic v, input logic b);
    logic pred, mt, e;
    @(negedge clk);
    bit_vld = v;
    bit_in  = b;
    e = 1'b0;
    if (v) begin
      pred = m_hist[13] ^ m_hist[14];
      mt   = (b == pred);
      if (!m_lock) begin                        // R2 / R3 hunting
        m_hist = {m_hist[13:0], b};
        m_erun = 0;
        if (mt) begin
          m_mrun++;
          if (m_mrun == 32) begin
            m_lock = 1'b1;
            m_mrun = 0;
          end
        end else begin
          m_mrun = 0;
        end
      end else begin                            // R4 / R5 locked
        m_hist = {m_hist[13:0], pred};
        m_mrun = 0;
        e = !mt;
        if (mt) begin
          m_erun = 0;
        end else begin
          m_erun++;
          if (m_erun == 4) begin
            m_lock = 1'b0;
            m_erun = 0;
          end
        end
      end
    end
    q_exp.push_back({!m_lock, e});
    q_tag.push_back(tag);
  endtask

  task automatic send(input int n, input logic flip);
    logic b;
    for (int i = 0; i < n; i++) begin
      b   = gen[13] ^ gen[14];
      gen = {gen[13:0], b};
      drive(1'b1, b ^ flip);
    end
  endtask

  task automatic send_gappy(input int n);
    logic b;
    for (int i = 0; i < n; i++) begin
      b   = gen[13] ^ gen[14];
      gen = {gen[13:0], b};
      drive(1'b1, b);
      if (i % 3 == 1) drive(1'b0, 1'($urandom));
    end
  endtask

  // Monitor: one expected pair per driven cycle, compared after the edge.
  always @(posedge clk) begin
    logic [1:0] exp_v;
    string      t;
    #1;
    if (q_exp.size() > 0) begin
      exp_v = q_exp.pop_front();
      t     = q_tag.pop_front();
      n_chk++;
      if ({oos, bit_err} !== exp_v) begin
        n_bad++;
        $display("FAIL %s: got oos=%b bit_err=%b expected oos=%b bit_err=%b",
                 t, oos, bit_err, exp_v[1], exp_v[0]);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_bad++;
      $display("FAIL watchdog: got cycles=%0d expected at most 50000", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
      $finish;
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    tag = "R1";  repeat (4) drive(1'b0, 1'b0);

    // R3: reach 31 matches, break with one miss, 31 again, still hunting.
    tag = "R3";
    send(20, 1'b0); send(1, 1'b1); send(15, 1'b0); send(31, 1'b0);
    send(1, 1'b1);  send(15, 1'b0); send(31, 1'b0);

    // R2: the 32nd consecutive match locks.
    tag = "R2";  send(1, 1'b0); send(20, 1'b0);

    // R7: idle cycles with toggling data while locked.
    tag = "R7";
    for (int i = 0; i < 6; i++) drive(1'b0, 1'(i));
    send_gappy(30);

    // R4: isolated errors give single pulses; reference unaffected.
    tag = "R4";
    send(10, 1'b0); send(1, 1'b1); send(10, 1'b0);
    send(1, 1'b1);  send(1, 1'b0); send(2, 1'b1); send(5, 1'b0);

    // R5: 3 miss, match, 3 miss keeps lock; then 4 miss drops it.
    tag = "R5";
    send(3, 1'b1); send(1, 1'b0); send(3, 1'b1); send(5, 1'b0);
    send(4, 1'b1);

    // R6: errors while hunting never pulse.
    tag = "R6";
    for (int i = 0; i < 40; i++) drive(1'b1, 1'($urandom));
    for (int i = 0; i < 10; i++) drive(1'b1, 1'(i % 2));

    tag = "R7";
    for (int i = 0; i < 6; i++) drive(1'b0, 1'(i + 1));

    // R8: relock from line data, then errors flag again.
    tag = "R8";
    send(80, 1'b0); send(1, 1'b1); send(4, 1'b0);

    tag = "R1";
    repeat (3) drive(1'b0, 1'b0);
    while (q_exp.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule